// File: doc/BRIEF.md
# Cascadable Tapped Serial Delay Line

This block delays a one-bit serial stream by a programmable number of clock cycles. It is built from 16-stage shift segments. Each segment moves its contents one place on every rising clock edge that has the shift enable high. A tap address picks any single stage for the tap output. The segments are chained through their last stages, so a parameter can set the line to 16, 32, 48 or 64 stages while one tap address spans the whole length.

The tap is read combinationally, so a new address shows up on the tap output within the same cycle. A separate cascade output always carries the final stage of the line, which lets another line be chained after it. An optional output flop on the tap adds exactly one more enabled cycle of delay. The stage contents have no reset and cannot be preloaded. The only way to change them is to shift data in, so anything that relies on the contents must first fill the line. When the enable pin is configured as unused, the line shifts on every edge.

Top module: `delayLine`

## Requirements
- R1: With the output flop off and a tap address N below the line depth, tapOut equals the serialIn value that was presented N+1 enabled edges earlier.
- R2: With the enable in use, a rising edge with shiftEn low changes no stage: tapOut and cascadeOut keep their values whatever serialIn does.
- R3: A change of tapAddr reaches tapOut without any clock edge. The tap is a combinational read of the stored stages.
- R4: On an enabled edge, stage 0 takes serialIn and every other stage takes the old value of the stage below it, so tap address 0 shows the bit shifted in by the most recent edge.
- R5: cascadeOut always carries the last stage, index NUM_SEG*16-1, whatever the tap address. Its delay is NUM_SEG*16 enabled edges.
- R6: The upper bits of tapAddr (tapAddr >> 4) select the segment and the low 4 bits select the stage within it. Addresses 15 and 16 are therefore consecutive stages across a segment boundary.
- R7: With OUT_REG set, tapOut is a flop that loads the addressed stage on each enabled edge. This gives a delay of N+2 enabled edges for a held address N, and the flop holds its value on a disabled edge.
- R8: With USE_ENABLE cleared, shiftEn is ignored and the line shifts on every rising edge.
- R9: A tapAddr at or beyond the line depth (possible when NUM_SEG is 3) reads the last stage, the same bit as cascadeOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| shiftEn | input | 1 | Shift enable; ignored when USE_ENABLE is 0 |
| serialIn | input | 1 | Serial data into stage 0 |
| tapAddr | input | ADDR_W = clog2(NUM_SEG*16) | Tap stage select |
| tapOut | output | 1 | Addressed stage, optionally registered |
| cascadeOut | output | 1 | Last stage of the line |

## Verification
The interesting overlaps come from a tap address change and a shift edge landing in the same cycle, and from a disabled edge coinciding with new serial data. The bench moves the address and the serial bit on the same falling edge that precedes a shift. It then compares the tap after the rising edge with a bench-side history of the accepted bits, which is the stage content after the shift and not before it. For the registered variant, the address is held across the edge and the flop is expected to show the stage one place deeper. Checks begin only after more bits than the line holds have been shifted in, because the power-up contents are unknown.

// File: rtl/delayLinePkg.sv
package delayLinePkg;

  localparam int STAGE_W    = 4;
  localparam int SEG_STAGES = 1 << STAGE_W;
  localparam int MAX_SEG    = 4;
  localparam int SEG_IDX_W  = $clog2(MAX_SEG);

  // Strobes and selects handed from control to datapath
  typedef struct packed {
    logic                 shiftStb;
    logic                 captureStb;
    logic [SEG_IDX_W-1:0] segIdx;
    logic [STAGE_W-1:0]   stageIdx;
  } lineStrobes_t;

endpackage

// File: rtl/shiftSegment.sv
module shiftSegment
  import delayLinePkg::*;
(
  input  logic               clk,
  input  logic               shiftStb,
  input  logic               dIn,
  input  logic [STAGE_W-1:0] stageIdx,
  output logic               tapBit,
  output logic               lastBit
);

  // No reset: contents change only by shifting
  logic [SEG_STAGES-1:0] stages;

  always_ff @(posedge clk) begin
    if (shiftStb) begin
      stages <= {stages[SEG_STAGES-2:0], dIn};
    end
  end

  assign tapBit  = stages[stageIdx];
  assign lastBit = stages[SEG_STAGES-1];

endmodule

// File: rtl/delayControl.sv
module delayControl
  import delayLinePkg::*;
#(
  parameter int NUM_SEG    = 4,
  parameter bit OUT_REG    = 1'b0,
  parameter bit USE_ENABLE = 1'b1,
  localparam int DEPTH     = NUM_SEG * SEG_STAGES,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              shiftEn,
  input  logic [ADDR_W-1:0] tapAddr,
  output lineStrobes_t      strobes
);

  logic [ADDR_W:0] addrExt;
  logic            outOfRange;
  logic            shiftNow;

  assign addrExt    = {1'b0, tapAddr};
  assign outOfRange = (addrExt >= (ADDR_W + 1)'(DEPTH));

  generate
    if (USE_ENABLE) begin : g_enUsed
      assign shiftNow = shiftEn;
    end else begin : g_enTied
      assign shiftNow = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.shiftStb   = shiftNow;
    strobes.captureStb = OUT_REG ? shiftNow : 1'b0;
    if (outOfRange) begin
      strobes.segIdx   = SEG_IDX_W'(NUM_SEG - 1);
      strobes.stageIdx = STAGE_W'(SEG_STAGES - 1);
    end else begin
      strobes.segIdx   = SEG_IDX_W'(addrExt >> STAGE_W);
      strobes.stageIdx = addrExt[STAGE_W-1:0];
    end
  end

endmodule

// File: rtl/delayDatapath.sv
module delayDatapath
  import delayLinePkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk,
  input  logic         serialIn,
  input  lineStrobes_t strobes,
  output logic         tapOut,
  output logic         cascadeOut
);

  logic [MAX_SEG:0]   chain;
  logic [MAX_SEG-1:0] segTap;
  logic               tapComb;

  assign chain[0] = serialIn;

  generate
    for (genvar i = 0; i < MAX_SEG; i++) begin : g_seg
      if (i < NUM_SEG) begin : g_live
        shiftSegment u_seg (
          .clk      (clk),
          .shiftStb (strobes.shiftStb),
          .dIn      (chain[i]),
          .stageIdx (strobes.stageIdx),
          .tapBit   (segTap[i]),
          .lastBit  (chain[i+1])
        );
      end else begin : g_absent
        assign segTap[i]  = 1'b0;
        assign chain[i+1] = chain[i];
      end
    end
  endgenerate

  assign tapComb    = segTap[strobes.segIdx];
  assign cascadeOut = chain[NUM_SEG];

  generate
    if (OUT_REG) begin : g_outReg
      logic tapQ;
      always_ff @(posedge clk) begin
        if (strobes.captureStb) begin
          tapQ <= tapComb;
        end
      end
      assign tapOut = tapQ;
    end else begin : g_outComb
      assign tapOut = tapComb;
    end
  endgenerate

endmodule

// File: rtl/delayLine.sv
module delayLine
  import delayLinePkg::*;
#(
  parameter int NUM_SEG    = 4,
  parameter bit OUT_REG    = 1'b0,
  parameter bit USE_ENABLE = 1'b1,
  localparam int ADDR_W    = $clog2(NUM_SEG * SEG_STAGES)
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic              serialIn,
  input  logic [ADDR_W-1:0] tapAddr,
  output logic              tapOut,
  output logic              cascadeOut
);

  lineStrobes_t strobes;

  delayControl #(
    .NUM_SEG    (NUM_SEG),
    .OUT_REG    (OUT_REG),
    .USE_ENABLE (USE_ENABLE)
  ) u_ctl (
    .shiftEn (shiftEn),
    .tapAddr (tapAddr),
    .strobes (strobes)
  );

  delayDatapath #(
    .NUM_SEG (NUM_SEG),
    .OUT_REG (OUT_REG)
  ) u_dp (
    .clk        (clk),
    .serialIn   (serialIn),
    .strobes    (strobes),
    .tapOut     (tapOut),
    .cascadeOut (cascadeOut)
  );

endmodule

// File: rtl/delayLineChk.sv
module delayLineChk #(
  parameter int NUM_SEG    = 4,
  parameter bit OUT_REG    = 1'b0,
  parameter bit USE_ENABLE = 1'b1,
  localparam int DEPTH     = NUM_SEG * 16,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              shiftEn,
  input logic              serialIn,
  input logic [ADDR_W-1:0] tapAddr,
  input logic              tapOut,
  input logic              cascadeOut
);

  // Contents have no reset; properties arm after the first edge
  logic armed = 1'b0;
  logic enEff;

  always_ff @(posedge clk) armed <= 1'b1;

  assign enEff = (USE_ENABLE == 1'b0) || shiftEn;

  // R4
  head_shift_chk: assert property (@(posedge clk) disable iff (!armed)
    (OUT_REG == 1'b0 && enEff) |=> (tapAddr != '0 || tapOut == $past(serialIn)));

  // R2
  hold_line_chk: assert property (@(posedge clk) disable iff (!armed)
    (USE_ENABLE != 1'b0 && !shiftEn) |=> $stable(cascadeOut));

  // R5
  last_tap_chk: assert property (@(posedge clk) disable iff (!armed)
    (OUT_REG == 1'b0 && tapAddr >= ADDR_W'(DEPTH - 1)) |-> tapOut == cascadeOut);

  // R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (OUT_REG != 1'b0 && !enEff) |=> $stable(tapOut));

endmodule

bind delayLine delayLineChk #(
  .NUM_SEG    (NUM_SEG),
  .OUT_REG    (OUT_REG),
  .USE_ENABLE (USE_ENABLE)
) chk (
  .clk        (clk),
  .shiftEn    (shiftEn),
  .serialIn   (serialIn),
  .tapAddr    (tapAddr),
  .tapOut     (tapOut),
  .cascadeOut (cascadeOut)
);

// File: tb/delayLine_test.sv
module delayLine_test;

  logic       clk = 1'b0;
  logic       shiftEn = 1'b1;
  logic       serialIn = 1'b0;
  logic [5:0] tapAddr = '0;
  logic [4:0] addrB = '0;
  logic       tapOut, cascadeOut;
  logic       tapTri, cascTri;
  logic       tapReg, cascReg;

  int applied = 0;
  int bad = 0;
  logic [127:0] hist  = '0;  // enabled-edge history, bit k = k+1 edges ago
  logic [127:0] histB = '0;  // every-edge history for the always-enabled line
  logic [7:0]   lfsr  = 8'hA5;

  always #10 clk = ~clk;

  delayLine uut (
    .clk(clk), .shiftEn(shiftEn), .serialIn(serialIn), .tapAddr(tapAddr),
    .tapOut(tapOut), .cascadeOut(cascadeOut));

  delayLine #(.NUM_SEG(3)) uutTri (
    .clk(clk), .shiftEn(shiftEn), .serialIn(serialIn), .tapAddr(tapAddr),
    .tapOut(tapTri), .cascadeOut(cascTri));

  delayLine #(.NUM_SEG(2), .OUT_REG(1'b1), .USE_ENABLE(1'b0)) uutReg (
    .clk(clk), .shiftEn(shiftEn), .serialIn(serialIn), .tapAddr(addrB),
    .tapOut(tapReg), .cascadeOut(cascReg));

  always @(posedge clk) begin
    if (shiftEn) hist <= {hist[126:0], serialIn};
    histB <= {histB[126:0], serialIn};
  end

  task automatic check(input string req, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic nextBit();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[0];
  endfunction

  // Drive on the falling edge, return 1 ns after the rising edge
  task automatic step(input logic din, input logic en);
    @(negedge clk);
    serialIn = din;
    shiftEn  = en;
    @(posedge clk);
    #1;
  endtask

  task automatic fillLine();
    for (int i = 0; i < 80; i++) step(nextBit(), 1'b1);
    check("R5 fill cascade", cascadeOut, hist[63]);
    check("R5 fill cascade 3seg", cascTri, hist[47]);
    check("R7 fill cascade 2seg", cascReg, histB[31]);
  endtask

  task automatic sweepTaps();
    step(nextBit(), 1'b0);
    for (int a = 0; a < 64; a++) begin
      tapAddr = 6'(a);
      #1;
      check("R1 R6 tap sweep", tapOut, hist[a]);
      check("R9 tap sweep 3seg", tapTri, hist[(a < 48) ? a : 47]);
      check("R5 cascade fixed", cascadeOut, hist[63]);
    end
  endtask

  task automatic combTap();
    shiftEn = 1'b0;
    for (int a = 63; a >= 0; a -= 7) begin
      tapAddr = 6'(a);
      #1;
      check("R3 comb tap", tapOut, hist[a]);
    end
  endtask

  task automatic headAndBoundary();
    for (int i = 0; i < 12; i++) begin
      logic d;
      d = (i % 3 == 0) ? 1'b1 : nextBit();
      @(negedge clk);
      tapAddr  = '0;
      serialIn = d;
      shiftEn  = 1'b1;
      @(posedge clk);
      #1;
      check("R4 head stage", tapOut, d);
      tapAddr = 6'd15;
      #1;
      check("R6 seg0 last", tapOut, hist[15]);
      tapAddr = 6'd16;
      #1;
      check("R6 seg1 first", tapOut, hist[16]);
    end
  endtask

  task automatic holdLine();
    logic t0, c0;
    step(nextBit(), 1'b1);
    tapAddr = 6'd37;
    #1;
    t0 = tapOut;
    c0 = cascadeOut;
    for (int i = 0; i < 10; i++) begin
      step(i[0], 1'b0);
      check("R2 hold tap", tapOut, t0);
      check("R2 hold cascade", cascadeOut, c0);
      check("R8 enable ignored", cascReg, histB[31]);
    end
  endtask

  task automatic regTap();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      addrB    = 5'((i * 5) % 31);
      serialIn = nextBit();
      shiftEn  = i[0];
      @(posedge clk);
      #1;
      check("R7 reg extra delay", tapReg, histB[addrB + 1]);
    end
  endtask

  task automatic sameCycle();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tapAddr  = 6'((i * 9) % 64);
      serialIn = nextBit();
      shiftEn  = (i % 4 != 3);
      @(posedge clk);
      #1;
      check("R1 addr with shift", tapOut, hist[tapAddr]);
      check("R5 cascade with shift", cascadeOut, hist[63]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    fillLine();
    sweepTaps();
    combTap();
    headAndBoundary();
    holdLine();
    regTap();
    sameCycle();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule